// File: doc/BRIEF.md
# Debug Trigger State Sequencer

This block is the sequencing core of an on-chip debug unit. A set of address comparators sits outside it. Each comparator sends a one-cycle match strobe into the sequencer. The sequencer then walks through three intermediate states toward a final state. Each comparator's match in each intermediate state can lead to its own programmed next state, so software can describe an ordered chain of bus events that must happen before the debug unit reacts.

Every comparator works in one of two modes. In forced mode a match moves the sequencer on the very next clock edge. In tag mode a match only records which instruction-queue slot was fetched. The move happens later, and only if the execute stage confirms that same slot. A flush throws such a pending tag away.

When the sequencer reaches the final state it gives a one-cycle trace-trigger pulse. It also gives a breakpoint request in the same cycle if breakpoints are enabled. It then falls back to idle and stays disarmed until the arm control is cycled. A software trigger can send the sequencer to the final state directly. While the core is in debug mode, comparator activity is ignored.

Top module: `dbg_trig_seq`

## Requirements
- R1: After reset, `state_o` is 0 (idle) and `trace_trig_o` and `brk_req_o` are low. State codes are: 0 idle, 1, 2 and 3 for the intermediate states, 4 final.
- R2: When `arm_i` is high and the sequencer is idle and not locked, it enters state 1 on the next edge. When `arm_i` is low, the next state is idle from any state, and this takes precedence over every other input.
- R3: In states 1 to 3, a forced-mode match on comparator c moves the sequencer on the next edge to the target held in `nxt_cfg_i[((s-1)*NUM_CMP+c)*2 +: 2]`, where s is the current state. Target code 0 means state 1, 1 means state 2, 2 means state 3 and 3 means final. Bit c of `cmp_tag_mode_i` is 0 for forced mode and 1 for tag mode.
- R4: In states 1 to 3, a tag-mode match stores `fetch_tag_i` for that comparator and does not change state. A later `exec_vld_i` whose `exec_tag_i` equals the stored tag counts as that comparator's match. A confirmation with a different tag has no effect.
- R5: `flush_i` discards all stored tags, so a later matching confirmation causes no transition. Any state change also discards them.
- R6: When several comparator events occur in the same cycle, whether forced or confirmed, the lowest-indexed comparator decides the next state.
- R7: The final state lasts exactly one cycle. `trace_trig_o` is high during exactly that cycle. `brk_req_o` is high in that cycle only if `brk_en_i` was high on the edge that entered the final state.
- R8: After the final state the sequencer returns to idle. It stays idle while `arm_i` remains high, and it re-arms only after `arm_i` has been low for at least one edge.
- R9: With `arm_i` high and the state not final, `sw_trig_i` moves the sequencer to the final state on the next edge. This overrides comparator events and the lock.
- R10: While `dbg_mode_i` is high, match strobes and execute confirmations are ignored. No state change results from them and no tag is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_i | input | 1 | Arm control; low forces idle |
| sw_trig_i | input | 1 | Software trigger strobe |
| brk_en_i | input | 1 | Breakpoint request enable |
| dbg_mode_i | input | 1 | Core in debug mode; comparators ignored |
| cmp_hit_i | input | NUM_CMP | Per-comparator match strobe |
| cmp_tag_mode_i | input | NUM_CMP | Per-comparator mode, 1 = tag, 0 = forced |
| fetch_tag_i | input | TAG_W | Queue slot of the fetch being matched |
| exec_vld_i | input | 1 | Execute-stage confirmation valid |
| exec_tag_i | input | TAG_W | Queue slot reaching execute |
| flush_i | input | 1 | Instruction queue flush |
| nxt_cfg_i | input | 3*NUM_CMP*2 | Next-state targets per state and comparator |
| state_o | output | 3 | Current sequencer state |
| trace_trig_o | output | 1 | One-cycle trace trigger |
| brk_req_o | output | 1 | One-cycle breakpoint request |

## Verification
The bench sets two comparators' events in one cycle, and also a confirmed tag alongside a forced match. A design with inverted priority would land in the other comparator's target state. It sends confirmations with a wrong tag and confirmations after a flush. A design that compared no tag or kept stale tags would advance there. It holds `arm_i` high through the final state to catch a design that re-arms by itself. It also drives a software trigger while disarmed and matches during debug mode, where any movement marks a wrong precedence.

// File: rtl/dbgseq_pkg.sv
package dbgseq_pkg;
   typedef enum logic [2:0] {
      SQ_IDLE  = 3'd0,
      SQ_ONE   = 3'd1,
      SQ_TWO   = 3'd2,
      SQ_THREE = 3'd3,
      SQ_FINAL = 3'd4
   } seq_state_e;

   localparam int TGT_W   = 2;
   localparam int MID_CNT = 3;

   function automatic seq_state_e tgt_to_state(input logic [TGT_W-1:0] code);
      case (code)
         2'd0:    return SQ_ONE;
         2'd1:    return SQ_TWO;
         2'd2:    return SQ_THREE;
         default: return SQ_FINAL;
      endcase
   endfunction
endpackage

// File: rtl/dbgseq_tag_slot.sv
module dbgseq_tag_slot #(
   parameter int TAG_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             load_i,
   input  logic [TAG_W-1:0] load_tag_i,
   input  logic             exec_vld_i,
   input  logic [TAG_W-1:0] exec_tag_i,
   output logic             fire_o
);
   logic             vld_q;
   logic [TAG_W-1:0] tag_q;

   assign fire_o = vld_q && exec_vld_i && (exec_tag_i == tag_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         tag_q <= '0;
      end else if (clear_i) begin
         vld_q <= 1'b0;
      end else if (load_i) begin
         vld_q <= 1'b1;
         tag_q <= load_tag_i;
      end else if (fire_o) begin
         vld_q <= 1'b0;
      end
   end
endmodule

// File: rtl/dbgseq_pick.sv
module dbgseq_pick
   import dbgseq_pkg::*;
#(
   parameter int NUM_CMP = 3,
   localparam int CFG_W  = MID_CNT * NUM_CMP * TGT_W
) (
   input  seq_state_e         cur_i,
   input  logic [NUM_CMP-1:0] ev_i,
   input  logic [CFG_W-1:0]   cfg_i,
   output logic               any_o,
   output seq_state_e         tgt_o
);
   logic [$clog2(MID_CNT)-1:0] row;

   always_comb begin
      row   = '0;
      any_o = |ev_i;
      tgt_o = SQ_ONE;
      case (cur_i)
         SQ_TWO:   row = 2'd1;
         SQ_THREE: row = 2'd2;
         default:  row = 2'd0;
      endcase
      // scan from the top so the lowest set index is applied last
      for (int c = NUM_CMP - 1; c >= 0; c--) begin
         if (ev_i[c])
            tgt_o = tgt_to_state(cfg_i[(int'(row) * NUM_CMP + c) * TGT_W +: TGT_W]);
      end
   end
endmodule

// File: rtl/dbg_trig_seq.sv
module dbg_trig_seq
   import dbgseq_pkg::*;
#(
   parameter int NUM_CMP  = 3,
   parameter int TAG_W    = 3,
   parameter bit USE_TAGS = 1'b1,
   localparam int CFG_W   = MID_CNT * NUM_CMP * TGT_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               arm_i,
   input  logic               sw_trig_i,
   input  logic               brk_en_i,
   input  logic               dbg_mode_i,
   input  logic [NUM_CMP-1:0] cmp_hit_i,
   input  logic [NUM_CMP-1:0] cmp_tag_mode_i,
   input  logic [TAG_W-1:0]   fetch_tag_i,
   input  logic               exec_vld_i,
   input  logic [TAG_W-1:0]   exec_tag_i,
   input  logic               flush_i,
   input  logic [CFG_W-1:0]   nxt_cfg_i,
   output logic [2:0]         state_o,
   output logic               trace_trig_o,
   output logic               brk_req_o
);
   if (NUM_CMP < 1 || NUM_CMP > 8) begin : g_bad_cmp
      $error("dbg_trig_seq: NUM_CMP must be 1..8");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("dbg_trig_seq: TAG_W must be at least 1");
   end

   seq_state_e         state_q, state_d, ev_tgt;
   logic               lock_q, trig_q, brk_q;
   logic               ev_any, in_mid, slot_clr;
   logic [NUM_CMP-1:0] hit_eff, forced_ev, tag_ev, ev_all;
   logic               exec_eff;

   assign in_mid    = (state_q == SQ_ONE) || (state_q == SQ_TWO) || (state_q == SQ_THREE);
   assign hit_eff   = dbg_mode_i ? '0 : cmp_hit_i;
   assign exec_eff  = exec_vld_i && !dbg_mode_i;
   assign forced_ev = hit_eff & ~cmp_tag_mode_i;
   assign ev_all    = forced_ev | tag_ev;
   assign slot_clr  = flush_i || (state_d != state_q);

   for (genvar c = 0; c < NUM_CMP; c++) begin : g_cmp
      if (USE_TAGS) begin : g_tag
         dbgseq_tag_slot #(.TAG_W(TAG_W)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .clear_i    (slot_clr),
            .load_i     (hit_eff[c] && cmp_tag_mode_i[c] && in_mid),
            .load_tag_i (fetch_tag_i),
            .exec_vld_i (exec_eff),
            .exec_tag_i (exec_tag_i),
            .fire_o     (tag_ev[c])
         );
      end else begin : g_notag
         assign tag_ev[c] = 1'b0;
      end
   end

   dbgseq_pick #(.NUM_CMP(NUM_CMP)) u_pick (
      .cur_i (state_q),
      .ev_i  (ev_all),
      .cfg_i (nxt_cfg_i),
      .any_o (ev_any),
      .tgt_o (ev_tgt)
   );

   always_comb begin
      state_d = state_q;
      if (!arm_i)                  state_d = SQ_IDLE;
      else if (state_q == SQ_FINAL) state_d = SQ_IDLE;
      else if (sw_trig_i)           state_d = SQ_FINAL;
      else if (state_q == SQ_IDLE) begin
         if (!lock_q)               state_d = SQ_ONE;
      end
      else if (in_mid && ev_any)    state_d = ev_tgt;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         lock_q  <= 1'b0;
         trig_q  <= 1'b0;
         brk_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         if (!arm_i)                  lock_q <= 1'b0;
         else if (state_q == SQ_FINAL) lock_q <= 1'b1;
         trig_q  <= (state_d == SQ_FINAL);
         brk_q   <= (state_d == SQ_FINAL) && brk_en_i;
      end
   end

   assign state_o      = state_q;
   assign trace_trig_o = trig_q;
   assign brk_req_o    = brk_q;
endmodule

// File: rtl/dbgseq_chk.sv
module dbgseq_chk #(
   parameter int NUM_CMP = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               arm_i,
   input logic               sw_trig_i,
   input logic               dbg_mode_i,
   input logic [2:0]         state_o,
   input logic               trace_trig_o,
   input logic               brk_req_o
);
   AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      state_o <= 3'd4);                                                       // R1
   AST_DISARM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !arm_i |=> state_o == 3'd0);                                            // R2
   AST_FINAL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      state_o == 3'd4 |=> state_o == 3'd0);                                   // R8
   AST_TRIG_WITH_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
      trace_trig_o == (state_o == 3'd4));                                     // R7
   AST_BRK_NEEDS_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
      brk_req_o |-> trace_trig_o);                                            // R7
   AST_SW_TRIG_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
      arm_i && sw_trig_i && state_o != 3'd4 |=> state_o == 3'd4);             // R9
   AST_DBG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_mode_i && arm_i && !sw_trig_i && state_o != 3'd0 && state_o != 3'd4
      |=> $stable(state_o));                                                  // R10
endmodule

bind dbg_trig_seq dbgseq_chk #(.NUM_CMP(NUM_CMP)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .arm_i        (arm_i),
   .sw_trig_i    (sw_trig_i),
   .dbg_mode_i   (dbg_mode_i),
   .state_o      (state_o),
   .trace_trig_o (trace_trig_o),
   .brk_req_o    (brk_req_o)
);

// File: tb/sim_dbg_trig_seq.sv
`timescale 1ns/1ps
module sim_dbg_trig_seq;
   localparam int NC = 3;
   localparam int TW = 3;
   // targets: S1 A->S2 B->S3 C->F ; S2 A->S3 B->S1 C->F ; S3 A->F B->S1 C->S2
   localparam logic [17:0] CFG = 18'b01_00_11_11_00_10_11_10_01;

   // {arm, sw, hit[2:0], mode[2:0], ftag, ev, etag, flush, exp_state, exp_trig}
   localparam int NV = 17;
   localparam logic [19:0] VEC [NV] = '{
      20'b0_0_000_000_000_0_000_0_000_0,  // R2 disarmed idle
      20'b1_0_000_000_000_0_000_0_001_0,  // R2 arm
      20'b1_0_001_000_000_0_000_0_010_0,  // R3 forced A
      20'b1_0_110_000_000_0_000_0_001_0,  // R6 B+C, B wins
      20'b1_0_010_010_101_0_000_0_001_0,  // R4 tag B slot 5
      20'b1_0_000_000_000_1_011_0_001_0,  // R4 wrong tag
      20'b1_0_000_000_000_1_101_0_011_0,  // R4 confirm
      20'b1_0_001_001_010_0_000_0_011_0,  // R4 tag A slot 2
      20'b1_0_000_000_000_0_000_1_011_0,  // R5 flush
      20'b1_0_000_000_000_1_010_0_011_0,  // R5 stale confirm
      20'b1_0_001_000_000_0_000_0_100_1,  // R7 forced A to final
      20'b1_0_000_000_000_0_000_0_000_0,  // R8 back to idle
      20'b1_0_000_000_000_0_000_0_000_0,  // R8 stays locked
      20'b0_0_000_000_000_0_000_0_000_0,  // R8 unlock
      20'b1_0_000_000_000_0_000_0_001_0,  // R8 re-arm
      20'b1_0_100_000_000_0_000_0_100_1,  // R3 forced C to final
      20'b0_0_000_000_000_0_000_0_000_0   // R2 disarm
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic arm = 0, sw = 0, brk_en = 1, dbg = 0, ev = 0, flush = 0;
   logic [NC-1:0] hit = '0, mode = '0;
   logic [TW-1:0] ftag = '0, etag = '0;
   logic [2:0] st;
   logic trig, brk;
   int errs = 0, checks = 0;
   bit done = 0;

   always #4 clk = ~clk;

   dbg_trig_seq #(.NUM_CMP(NC), .TAG_W(TW)) u0 (
      .clk(clk), .rst_n(rst_n), .arm_i(arm), .sw_trig_i(sw), .brk_en_i(brk_en),
      .dbg_mode_i(dbg), .cmp_hit_i(hit), .cmp_tag_mode_i(mode), .fetch_tag_i(ftag),
      .exec_vld_i(ev), .exec_tag_i(etag), .flush_i(flush), .nxt_cfg_i(CFG),
      .state_o(st), .trace_trig_o(trig), .brk_req_o(brk));

   task automatic chk(input string req, input logic [2:0] es, input logic et, input logic eb);
      checks++;
      if (st !== es || trig !== et || brk !== eb) begin
         errs++;
         $display("FAIL %s: state=%0d trig=%0b brk=%0b expected state=%0d trig=%0b brk=%0b",
                  req, st, trig, brk, es, et, eb);
      end
   endtask

   task automatic idle_in();
      sw = 0; hit = '0; mode = '0; ftag = '0; ev = 0; etag = '0; flush = 0;
   endtask

   task automatic cyc();
      @(posedge clk); @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   endtask

   initial begin
      #(8 * 200000);
      errs++;
      $display("FAIL watchdog: run did not end, expected completion");
      finish_run();
   end

   initial begin
      @(negedge clk); cyc(); cyc();
      chk("R1 reset", 3'd0, 1'b0, 1'b0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         {arm, sw, hit, mode, ftag, ev, etag, flush} = VEC[i][19:4];
         cyc();
         chk($sformatf("vector %0d", i), VEC[i][3:1], VEC[i][0], VEC[i][0]);
      end
      idle_in();

      // R9 software trigger with breakpoint enabled
      arm = 1; cyc(); hit = 3'b001; cyc(); hit = '0;
      chk("R3 to S2", 3'd2, 0, 0);
      sw = 1; cyc(); sw = 0;
      chk("R9 sw trig brk on", 3'd4, 1, 1);
      cyc(); chk("R7 pulse ends", 3'd0, 0, 0);

      // R7 breakpoint disabled
      arm = 0; cyc(); arm = 1; brk_en = 0; cyc();
      sw = 1; cyc(); sw = 0;
      chk("R7 brk disabled", 3'd4, 1, 0);
      brk_en = 1;

      // R2 disarm mid-sequence
      arm = 0; cyc(); arm = 1; cyc(); hit = 3'b001; cyc(); hit = '0;
      arm = 0; cyc();
      chk("R2 disarm from S2", 3'd0, 0, 0);

      // R2 software trigger ignored while disarmed
      sw = 1; cyc(); sw = 0;
      chk("R2 sw while disarmed", 3'd0, 0, 0);

      // R10 debug mode blocks forced and tagged matches
      arm = 1; cyc(); dbg = 1;
      hit = 3'b001; cyc();
      chk("R10 forced ignored", 3'd1, 0, 0);
      mode = 3'b010; hit = 3'b010; ftag = 3'd4; cyc(); idle_in();
      dbg = 0; ev = 1; etag = 3'd4; cyc(); ev = 0;
      chk("R10 no tag stored", 3'd1, 0, 0);

      // R6 confirmed tag on A against forced B in same cycle: A wins -> S2
      mode = 3'b001; hit = 3'b001; ftag = 3'd1; cyc(); idle_in();
      chk("R4 tag holds state", 3'd1, 0, 0);
      ev = 1; etag = 3'd1; hit = 3'b010; cyc(); idle_in();
      chk("R6 tag A beats forced B", 3'd2, 0, 0);

      arm = 0; cyc();
      chk("R2 final disarm", 3'd0, 0, 0);
      finish_run();
   end
endmodule